// File: doc/BRIEF.md
# Link-Layer Flit Framer with Replay

This block is the link layer of a point-to-point serial interconnect, covering both directions of one lane group. On the transmit side it accepts payloads from the layer above and gives each one a sequence number and a CRC-8. The resulting 80-bit flit goes out as four 20-bit physical units on consecutive cycles. Every flit stays in an eight-entry replay store until the far end acknowledges it.

On the receive side the block collects four physical units into a flit and checks its CRC. A correct flit carrying the expected sequence number is handed upstream through a valid/ready holding register. A flit with a bad CRC triggers a replay request naming the expected sequence number, and every flit that does not carry that number is discarded. When the transmitter sees a replay request, it winds its send pointer back and sends the stored flits again, in order.

Acknowledge and replay indications come out of the receiver as a sideband and go into the transmitter as a separate sideband. In a loopback setup the two are wired together, so a payload put in at one end comes out upstream exactly once and in order, even when physical units are corrupted on the way.

Top module: `flit_link`

## Requirements
- R1: A flit holds the payload in bits 67:0, the sequence number in bits 71:68 and a CRC-8 in bits 79:72. The CRC uses polynomial 0x07 with an initial value of zero and is computed over bits 71:0, taking bit 71 first.
- R2: A flit is sent as four units on consecutive cycles with `phy_tx_valid` high, and unit k carries flit bits 20k+19 down to 20k.
- R3: After reset, accepted payloads receive sequence numbers 0, 1, 2 and so on, counting modulo 16 in acceptance order.
- R4: A received flit with a good CRC, the expected sequence number and a free holding register is presented on `rx_payload`. `lnk_ack` then pulses with that sequence number on the cycle after its last unit.
- R5: The replay store holds 8 flits, and `tx_ready` is low while 8 flits are unacknowledged. An acknowledge whose sequence number lies in the unacknowledged window frees every entry up to and including that number. An acknowledge outside the window is ignored.
- R6: A received flit with a bad CRC is discarded, and `lnk_nak` pulses with the expected sequence number on the cycle after its last unit.
- R7: A received flit with a good CRC but an unexpected sequence number is discarded silently: there is no delivery, no acknowledge and no replay request.
- R8: A replay request for a sequence number inside the window frees all older entries. Once the flit in progress has finished, the transmitter resends in order starting from the requested number.
- R9: `rx_valid` and `rx_payload` hold until `rx_ready` is seen. An expected flit that arrives while the holding register is still occupied is discarded and a replay request is issued for it.
- R10: In loopback, every accepted payload is delivered upstream exactly once and in acceptance order, including when physical units are corrupted.
- R11: After reset, `tx_ready` is high and both `phy_tx_valid` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Payload offered for sending |
| tx_ready | output | 1 | Replay store has a free entry |
| tx_payload | input | 68 | Payload to send |
| phy_tx_valid | output | 1 | Physical unit valid on the transmit path |
| phy_tx_unit | output | 20 | Transmitted physical unit |
| phy_rx_valid | input | 1 | Physical unit valid on the receive path |
| phy_rx_unit | input | 20 | Received physical unit |
| lnk_ack | output | 1 | Receiver acknowledges `lnk_seq` |
| lnk_nak | output | 1 | Receiver requests replay from `lnk_seq` |
| lnk_seq | output | 4 | Sequence number of the acknowledge or replay request |
| peer_ack | input | 1 | Acknowledge from the far receiver |
| peer_nak | input | 1 | Replay request from the far receiver |
| peer_seq | input | 4 | Sequence number for `peer_ack` or `peer_nak` |
| rx_valid | output | 1 | Delivered payload valid |
| rx_ready | input | 1 | Upstream accepts the payload |
| rx_payload | output | 68 | Delivered payload |

## Verification
The in-module assertions check several properties on every cycle:
- the unacknowledged count never exceeds the store depth, and the send pointer stays inside the window;
- a flit's units leave without gaps, and nothing is written while the store is full;
- an acknowledge and a replay request never pulse together;
- the upstream holding register stays stable under backpressure.

Other behaviour can only be shown by the bench scenarios, which follow bit-exact flits and sequences:
- the exact flit layout and CRC value, and the cycle on which an acknowledge pulses;
- silent discarding of flits that are out of sequence, and rejection of out-of-window acknowledges;
- a rewind to the requested sequence number;
- exactly-once, in-order delivery after an injected unit error and under upstream backpressure.

// File: rtl/flk_pkg.sv
`timescale 1ns/1ps
package flk_pkg;
   localparam int FLK_PAY_W  = 68;
   localparam int FLK_SEQ_W  = 4;
   localparam int FLK_CRC_W  = 8;
   localparam int FLK_UNIT_W = 20;
   localparam int FLK_DEPTH  = 8;

   // Receiver decision for one completed flit
   typedef enum logic [1:0] {
      VD_NONE   = 2'd0,
      VD_TAKE   = 2'd1,
      VD_DROP   = 2'd2,
      VD_REPLAY = 2'd3
   } verdict_e;
endpackage

// File: rtl/flt_crc.sv
`timescale 1ns/1ps
module flt_crc #(
   parameter int DATA_W = 72,
   parameter int CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY = 8'h07
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   // Bit-serial division unrolled; most significant data bit enters first.
   always_comb begin
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = acc[CRC_W-1] ^ data[i];
         acc = {acc[CRC_W-2:0], 1'b0};
         if (fb) acc = acc ^ POLY;
      end
      crc = acc;
   end
endmodule

// File: rtl/flt_tx.sv
`timescale 1ns/1ps
module flt_tx #(
   parameter int PAY_W  = 68,
   parameter int SEQ_W  = 4,
   parameter int CRC_W  = 8,
   parameter int UNIT_W = 20,
   parameter int DEPTH  = 8,
   parameter logic [CRC_W-1:0] POLY = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PAY_W-1:0]  in_payload,
   output logic              phy_valid,
   output logic [UNIT_W-1:0] phy_unit,
   input  logic              fb_ack,
   input  logic              fb_nak,
   input  logic [SEQ_W-1:0]  fb_seq
);
   localparam int FLIT_W = PAY_W + SEQ_W + CRC_W;
   localparam int NUNITS = FLIT_W / UNIT_W;
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int BEAT_W = (NUNITS > 1) ? $clog2(NUNITS) : 1;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUNITS - 1);
   localparam logic [SEQ_W-1:0]  DEPTH_S   = SEQ_W'(DEPTH);

   logic [SEQ_W-1:0]  base_q, wr_q, rd_q;
   logic [PAY_W-1:0]  store_q [DEPTH];
   logic [FLIT_W-1:0] sh_q;
   logic [BEAT_W-1:0] beat_q;
   logic              busy_q;

   logic [SEQ_W-1:0]  used, fb_off, ack_next, rd_step;
   logic              accept, ack_ok, nak_ok, avail, beat_last, load;
   logic [PAY_W-1:0]  rd_payload;
   logic [CRC_W-1:0]  tx_crc;

   assign used      = wr_q - base_q;
   assign in_ready  = (used != DEPTH_S);
   assign accept    = in_valid & in_ready;
   assign fb_off    = fb_seq - base_q;
   assign ack_ok    = fb_ack & (fb_off < used);
   assign nak_ok    = fb_nak & (fb_off <= used);
   assign ack_next  = fb_seq + 1'b1;
   assign avail     = (rd_q != wr_q);
   assign beat_last = busy_q & (beat_q == LAST_BEAT);
   assign load      = avail & (~busy_q | beat_last);
   assign rd_step   = load ? rd_q + 1'b1 : rd_q;

   assign rd_payload = store_q[rd_q[IDX_W-1:0]];

   flt_crc #(.DATA_W(PAY_W + SEQ_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
      .data ({rd_q, rd_payload}),
      .crc  (tx_crc)
   );

   // Replay store: payload only; the header is rebuilt on every send.
   always_ff @(posedge clk) begin
      if (accept) store_q[wr_q[IDX_W-1:0]] <= in_payload;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         wr_q   <= '0;
         rd_q   <= '0;
      end else begin
         if (accept) wr_q <= wr_q + 1'b1;
         if (nak_ok) begin
            base_q <= fb_seq;
            rd_q   <= fb_seq;
         end else begin
            if (ack_ok) base_q <= ack_next;
            // An acknowledge past the send pointer drags the pointer along.
            if (ack_ok && ((rd_step - base_q) < (ack_next - base_q)))
               rd_q <= ack_next;
            else
               rd_q <= rd_step;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         beat_q <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         sh_q   <= {tx_crc, rd_q, rd_payload};
         beat_q <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         sh_q   <= sh_q >> UNIT_W;
         beat_q <= beat_q + 1'b1;
         if (beat_last) busy_q <= 1'b0;
      end
   end

   assign phy_valid = busy_q;
   assign phy_unit  = sh_q[UNIT_W-1:0];

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      used <= DEPTH_S);
   assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> $stable(wr_q));
   assert_rd_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q - base_q) <= used);
   assert_units_gapless_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_valid && beat_q != LAST_BEAT) |=> phy_valid);
endmodule

// File: rtl/flt_rx.sv
`timescale 1ns/1ps
module flt_rx
   import flk_pkg::*;
#(
   parameter int PAY_W  = 68,
   parameter int SEQ_W  = 4,
   parameter int CRC_W  = 8,
   parameter int UNIT_W = 20,
   parameter logic [CRC_W-1:0] POLY = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phy_valid,
   input  logic [UNIT_W-1:0] phy_unit,
   output logic              ack,
   output logic              nak,
   output logic [SEQ_W-1:0]  seq,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PAY_W-1:0]  out_payload
);
   localparam int FLIT_W = PAY_W + SEQ_W + CRC_W;
   localparam int NUNITS = FLIT_W / UNIT_W;
   localparam int HOLD_N = (NUNITS > 1) ? NUNITS - 1 : 1;
   localparam int BEAT_W = (NUNITS > 1) ? $clog2(NUNITS) : 1;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUNITS - 1);

   logic [UNIT_W-1:0] hold_q [HOLD_N];
   logic [BEAT_W-1:0] beat_q;
   logic [SEQ_W-1:0]  exp_q, seq_q;
   logic              ack_q, nak_q, ov_q;
   logic [PAY_W-1:0]  pay_q;

   logic [FLIT_W-1:0] flit_w;
   logic [CRC_W-1:0]  rx_crc;
   logic              done, crc_ok, slot_free;
   verdict_e          verdict;

   // Earlier units of the flit wait here; the last unit is used directly.
   for (genvar gi = 0; gi < NUNITS - 1; gi++) begin : g_hold
      always_ff @(posedge clk) begin
         if (phy_valid && beat_q == BEAT_W'(gi)) hold_q[gi] <= phy_unit;
      end
      assign flit_w[gi*UNIT_W +: UNIT_W] = hold_q[gi];
   end
   if (NUNITS == 1) begin : g_single
      always_ff @(posedge clk) hold_q[0] <= '0;
   end
   assign flit_w[FLIT_W-1 -: UNIT_W] = phy_unit;

   flt_crc #(.DATA_W(PAY_W + SEQ_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
      .data (flit_w[PAY_W+SEQ_W-1:0]),
      .crc  (rx_crc)
   );

   assign done      = phy_valid & (beat_q == LAST_BEAT);
   assign crc_ok    = (rx_crc == flit_w[FLIT_W-1 -: CRC_W]);
   assign slot_free = ~ov_q | out_ready;

   always_comb begin
      if (!done)                                   verdict = VD_NONE;
      else if (!crc_ok)                            verdict = VD_REPLAY;
      else if (flit_w[PAY_W +: SEQ_W] != exp_q)    verdict = VD_DROP;
      else if (!slot_free)                         verdict = VD_REPLAY;
      else                                         verdict = VD_TAKE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
         exp_q  <= '0;
         seq_q  <= '0;
         ack_q  <= 1'b0;
         nak_q  <= 1'b0;
         ov_q   <= 1'b0;
         pay_q  <= '0;
      end else begin
         if (phy_valid) beat_q <= done ? '0 : beat_q + 1'b1;
         ack_q <= (verdict == VD_TAKE);
         nak_q <= (verdict == VD_REPLAY);
         if (verdict == VD_TAKE || verdict == VD_REPLAY) seq_q <= exp_q;
         if (verdict == VD_TAKE) begin
            exp_q <= exp_q + 1'b1;
            ov_q  <= 1'b1;
            pay_q <= flit_w[PAY_W-1:0];
         end else if (out_ready) begin
            ov_q  <= 1'b0;
         end
      end
   end

   assign ack         = ack_q;
   assign nak         = nak_q;
   assign seq         = seq_q;
   assign out_valid   = ov_q;
   assign out_payload = pay_q;

   assert_ack_nak_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && nak));
   assert_ack_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (exp_q == seq + 1'b1));
   assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));
   assert_ack_delivers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> out_valid);
endmodule

// File: rtl/flit_link.sv
`timescale 1ns/1ps
module flit_link
   import flk_pkg::*;
#(
   parameter int PAY_W  = FLK_PAY_W,
   parameter int SEQ_W  = FLK_SEQ_W,
   parameter int CRC_W  = FLK_CRC_W,
   parameter int UNIT_W = FLK_UNIT_W,
   parameter int DEPTH  = FLK_DEPTH,
   parameter logic [CRC_W-1:0] POLY = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [PAY_W-1:0]  tx_payload,
   output logic              phy_tx_valid,
   output logic [UNIT_W-1:0] phy_tx_unit,
   input  logic              phy_rx_valid,
   input  logic [UNIT_W-1:0] phy_rx_unit,
   output logic              lnk_ack,
   output logic              lnk_nak,
   output logic [SEQ_W-1:0]  lnk_seq,
   input  logic              peer_ack,
   input  logic              peer_nak,
   input  logic [SEQ_W-1:0]  peer_seq,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [PAY_W-1:0]  rx_payload
);
   localparam int FLIT_W = PAY_W + SEQ_W + CRC_W;

   if (FLIT_W % UNIT_W != 0) begin : g_bad_unit
      $error("flit width must be a whole number of physical units");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("replay depth must be a power of two of at least 2");
   end
   if (DEPTH >= (1 << SEQ_W)) begin : g_bad_seq
      $error("sequence space must exceed the replay depth");
   end
   if (CRC_W < 2) begin : g_bad_crc
      $error("CRC must be at least two bits");
   end

   flt_tx #(.PAY_W(PAY_W), .SEQ_W(SEQ_W), .CRC_W(CRC_W), .UNIT_W(UNIT_W),
            .DEPTH(DEPTH), .POLY(POLY)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (tx_valid),
      .in_ready   (tx_ready),
      .in_payload (tx_payload),
      .phy_valid  (phy_tx_valid),
      .phy_unit   (phy_tx_unit),
      .fb_ack     (peer_ack),
      .fb_nak     (peer_nak),
      .fb_seq     (peer_seq)
   );

   flt_rx #(.PAY_W(PAY_W), .SEQ_W(SEQ_W), .CRC_W(CRC_W), .UNIT_W(UNIT_W),
            .POLY(POLY)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .phy_valid   (phy_rx_valid),
      .phy_unit    (phy_rx_unit),
      .ack         (lnk_ack),
      .nak         (lnk_nak),
      .seq         (lnk_seq),
      .out_valid   (rx_valid),
      .out_ready   (rx_ready),
      .out_payload (rx_payload)
   );
endmodule

// File: tb/sim_flit_link.sv
`timescale 1ns/1ps
module sim_flit_link;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [67:0] tx_payload = '0;
   logic        phy_tx_valid;
   logic [19:0] phy_tx_unit;
   logic        phy_rx_valid;
   logic [19:0] phy_rx_unit;
   logic        lnk_ack, lnk_nak;
   logic [3:0]  lnk_seq;
   logic        peer_ack, peer_nak;
   logic [3:0]  peer_seq;
   logic        rx_valid;
   logic        rx_ready = 1'b1;
   logic [67:0] rx_payload;

   // Loopback control
   logic        loop_phy = 1'b1, loop_fb = 1'b1;
   logic        man_pv = 1'b0;
   logic [19:0] man_pu = '0;
   logic        man_ack = 1'b0, man_nak = 1'b0;
   logic [3:0]  man_seq = '0;
   int          err_beat = -1;
   logic [19:0] err_mask = 20'h00400;

   int beat_idx = 0, cyc = 0;
   int sent_total = 0, dlv = 0;
   int ack_cnt = 0, nak_cnt = 0, last_ack_cyc = 0;
   logic [3:0] last_ack_seq = '0, last_nak_seq = '0;
   logic [67:0] exp_pay [0:255];
   logic [19:0] cap_unit [0:4095];
   int          cap_cyc  [0:4095];
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assign phy_rx_valid = loop_phy ? phy_tx_valid : man_pv;
   assign phy_rx_unit  = loop_phy ? (phy_tx_unit ^ ((beat_idx == err_beat) ? err_mask : 20'h0))
                                  : man_pu;
   assign peer_ack = loop_fb ? lnk_ack : man_ack;
   assign peer_nak = loop_fb ? lnk_nak : man_nak;
   assign peer_seq = loop_fb ? lnk_seq : man_seq;

   flit_link u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_payload(tx_payload),
      .phy_tx_valid(phy_tx_valid), .phy_tx_unit(phy_tx_unit),
      .phy_rx_valid(phy_rx_valid), .phy_rx_unit(phy_rx_unit),
      .lnk_ack(lnk_ack), .lnk_nak(lnk_nak), .lnk_seq(lnk_seq),
      .peer_ack(peer_ack), .peer_nak(peer_nak), .peer_seq(peer_seq),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_payload(rx_payload)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (phy_tx_valid) beat_idx <= beat_idx + 1;
   end

   // Monitors sample mid-cycle.
   always @(negedge clk) begin
      if (rst_n) begin
         if (phy_tx_valid && beat_idx < 4096) begin
            cap_unit[beat_idx] = phy_tx_unit;
            cap_cyc[beat_idx]  = cyc;
         end
         if (lnk_ack) begin ack_cnt++; last_ack_seq = lnk_seq; last_ack_cyc = cyc; end
         if (lnk_nak) begin nak_cnt++; last_nak_seq = lnk_seq; end
         if (rx_valid && rx_ready) begin
            checks++;
            if (dlv >= sent_total || rx_payload !== exp_pay[dlv & 255]) begin
               errors++;
               $display("FAIL R10 delivery %0d: got %h expected %h (sent %0d)",
                        dlv, rx_payload, exp_pay[dlv & 255], sent_total);
            end
            dlv++;
         end
      end
   end

   function automatic logic [79:0] mk_flit(input logic [3:0] s, input logic [67:0] p);
      logic [71:0] h;
      logic [7:0]  c;
      logic        top;
      h = {s, p};
      c = 8'h00;
      for (int i = 71; i >= 0; i--) begin
         top = c[7] ^ h[i];
         c = {c[6:0], 1'b0};
         if (top) c = c ^ 8'h07;
      end
      return {c, h};
   endfunction

   function automatic logic [67:0] pat(input int i);
      return {4'(i) ^ 4'h9, 32'hC0DE0000 + 32'(i * 13), 32'h5A5A0000 ^ 32'(i * 977)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [79:0] act,
                      input logic [79:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic send(input logic [67:0] p);
      @(posedge clk); #1;
      tx_valid = 1'b1; tx_payload = p;
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      @(posedge clk); #1;
      tx_valid = 1'b0;
      exp_pay[sent_total & 255] = p;
      sent_total++;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_deliver(input string req);
      int guard = 0;
      while (dlv < sent_total && guard < 4000) begin @(posedge clk); guard++; end
      idle(40);
      chk(dlv == sent_total, req, 80'(dlv), 80'(sent_total));
   endtask

   task automatic pulse_fb(input bit is_nak, input logic [3:0] s);
      @(posedge clk); #1;
      man_seq = s;
      if (is_nak) man_nak = 1'b1; else man_ack = 1'b1;
      @(posedge clk); #1;
      man_ack = 1'b0; man_nak = 1'b0;
   endtask

   task automatic drive_flit(input logic [79:0] f);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         man_pv = 1'b1; man_pu = f[20*k +: 20];
      end
      @(posedge clk); #1;
      man_pv = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(tx_ready == 1'b1, "R11 tx_ready", 80'(tx_ready), 80'(1));
      chk(phy_tx_valid == 1'b0, "R11 phy_tx_valid", 80'(phy_tx_valid), 80'(0));
      chk(rx_valid == 1'b0, "R11 rx_valid", 80'(rx_valid), 80'(0));
   endtask

   task automatic t_format;
      int b0 = beat_idx;
      logic [3:0]  s = 4'(sent_total);
      logic [67:0] p = 68'hF_0123_4567_89AB_CDEF;
      logic [79:0] f = mk_flit(s, p);
      logic [79:0] got;
      send(p);
      idle(12);
      for (int k = 0; k < 4; k++) got[20*k +: 20] = cap_unit[b0 + k];
      chk(got[79:68] == f[79:68], "R1 crc and sequence field", got, f);
      chk(got == f, "R2 unit order", got, f);
      chk(cap_cyc[b0+3] - cap_cyc[b0] == 3, "R2 consecutive units",
          80'(cap_cyc[b0+3] - cap_cyc[b0]), 80'(3));
      chk(last_ack_seq == s && last_ack_cyc == cap_cyc[b0+3] + 1, "R4 ack seq and timing",
          {4'(last_ack_seq), 76'(last_ack_cyc)}, {4'(s), 76'(cap_cyc[b0+3] + 1)});
      wait_deliver("R4 delivery");
   endtask

   task automatic t_stream;
      int b0 = beat_idx;
      int s0 = sent_total;
      for (int i = 0; i < 10; i++) send(pat(100 + i));
      wait_deliver("R10 stream delivery");
      for (int i = 0; i < 10; i++) begin
         logic [3:0] hs = cap_unit[b0 + 4*i + 3][11:8];
         chk(hs == 4'(s0 + i), "R3 sequence numbering", 80'(hs), 80'(4'(s0 + i)));
      end
   endtask

   task automatic t_crc_error;
      int n0 = nak_cnt;
      logic [3:0] s = 4'(sent_total + 2);
      err_beat = beat_idx + 9;
      for (int i = 0; i < 6; i++) send(pat(200 + i));
      wait_deliver("R10 delivery after unit error");
      err_beat = -1;
      chk(nak_cnt > n0, "R6 replay requested", 80'(nak_cnt), 80'(n0 + 1));
      chk(last_nak_seq == s, "R6 replay sequence", 80'(last_nak_seq), 80'(s));
   endtask

   task automatic t_backpressure;
      int n0 = nak_cnt;
      rx_ready = 1'b0;
      for (int i = 0; i < 3; i++) send(pat(300 + i));
      idle(40);
      chk(rx_valid == 1'b1 && rx_payload == exp_pay[dlv & 255], "R9 hold under backpressure",
          80'(rx_payload), 80'(exp_pay[dlv & 255]));
      chk(nak_cnt > n0, "R9 replay when occupied", 80'(nak_cnt), 80'(n0 + 1));
      rx_ready = 1'b1;
      wait_deliver("R9 delivery after release");
   endtask

   task automatic t_full;
      logic [3:0] s0 = 4'(sent_total);
      loop_fb = 1'b0;
      for (int i = 0; i < 8; i++) send(pat(400 + i));
      idle(2);
      chk(tx_ready == 1'b0, "R5 full after 8", 80'(tx_ready), 80'(0));
      idle(60);
      chk(tx_ready == 1'b0, "R5 stays full without ack", 80'(tx_ready), 80'(0));
      pulse_fb(1'b0, s0 - 4'd1);
      idle(2);
      chk(tx_ready == 1'b0, "R5 out-of-window ack ignored", 80'(tx_ready), 80'(0));
      pulse_fb(1'b0, s0 + 4'd3);
      idle(2);
      chk(tx_ready == 1'b1, "R5 ack frees entries", 80'(tx_ready), 80'(1));
      pulse_fb(1'b0, s0 + 4'd7);
      wait_deliver("R5 delivery of full window");
      loop_fb = 1'b1;
   endtask

   task automatic t_nak_rewind;
      logic [3:0] s0 = 4'(sent_total);
      int b;
      int d0;
      loop_fb = 1'b0;
      for (int i = 0; i < 3; i++) send(pat(500 + i));
      wait_deliver("R8 initial delivery");
      d0 = dlv;
      b = beat_idx;
      pulse_fb(1'b1, s0 + 4'd1);
      idle(30);
      chk(beat_idx - b == 8, "R8 resend count", 80'(beat_idx - b), 80'(8));
      chk(cap_unit[b+3][11:8] == s0 + 4'd1, "R8 resend first seq",
          80'(cap_unit[b+3][11:8]), 80'(s0 + 4'd1));
      chk(cap_unit[b+7][11:8] == s0 + 4'd2, "R8 resend second seq",
          80'(cap_unit[b+7][11:8]), 80'(s0 + 4'd2));
      chk(dlv == d0, "R7 duplicates not delivered", 80'(dlv), 80'(d0));
      pulse_fb(1'b0, s0 + 4'd2);
      idle(2);
      loop_fb = 1'b1;
   endtask

   task automatic t_direct_rx;
      logic [3:0] e = 4'(sent_total);
      int a0 = ack_cnt, n0 = nak_cnt, d0 = dlv;
      logic [79:0] f;
      loop_phy = 1'b0; loop_fb = 1'b0;
      drive_flit(mk_flit(e + 4'd1, pat(600)));
      idle(10);
      chk(ack_cnt == a0 && nak_cnt == n0 && dlv == d0 && !rx_valid,
          "R7 wrong sequence silent", {16'(ack_cnt), 16'(nak_cnt), 48'(dlv)},
          {16'(a0), 16'(n0), 48'(d0)});
      f = mk_flit(e, pat(601));
      f[5] = ~f[5];
      drive_flit(f);
      idle(10);
      chk(nak_cnt == n0 + 1 && last_nak_seq == e && ack_cnt == a0 && dlv == d0,
          "R6 bad crc dropped with replay", {16'(nak_cnt), 64'(last_nak_seq)},
          {16'(n0 + 1), 64'(e)});
      loop_phy = 1'b1; loop_fb = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_format();
      t_stream();
      t_crc_error();
      t_backpressure();
      t_full();
      t_nak_rewind();
      t_direct_rx();
      t_stream();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule